// File: doc/BRIEF.md
# Bidirectional Control-Signal Repeater

This block passes one active-low control line across a bus extender that joins two segments, called A and B. The line is shared in wired-OR fashion, so a low level means asserted. On each segment the block reads the line and can pull it low through an output enable. An assertion on either segment is seen through a two-flop synchronizer, and the block then drives the same assertion onto the other segment. While it drives a segment, the block ignores the input from that segment, so its own output cannot be taken as a new source.

The driven pulse is never shorter than a minimum hold time, `FILT_CYC` cycles. A longer source pulse is copied at its own length. When the source lets go, the block drives the line high for one cycle and then stops driving it. It then waits `GUARD_CYC` cycles before it samples either segment again, so that echoes on the bus are not mistaken for a new pulse.

The control is a five-state machine:
- IDLE: nothing is driven and both inputs are watched.
- DRIVE_A_TO_B: segment B is held low.
- DRIVE_B_TO_A: segment A is held low.
- RELEASE: the driven segment is driven high for one cycle.
- GUARD: nothing is driven and both inputs are ignored.

The transitions are:
- IDLE→DRIVE_A_TO_B when A is asserted.
- IDLE→DRIVE_B_TO_A when only B is asserted.
- DRIVE_*→RELEASE when the hold time has run out and the source input is deasserted.
- RELEASE→GUARD always.
- GUARD→IDLE when the guard time has run out.

Top module: `sig_repeater`

## Requirements
- R1: A synchronous active-high reset places the block in IDLE. After reset both output enables are 0 and both output values are 1.
- R2: An assertion (logic 0) on one segment, accepted in IDLE, makes the block drive the other segment: output enable 1 and output value 0.
- R3: If both segments are asserted in the same IDLE cycle, A to B wins. Segment B is driven and segment A is not.
- R4: While one segment is being driven, the input of that segment has no effect, and the block never enables both outputs at once.
- R5: Once a leading edge has been accepted, the driven output stays low for at least `FILT_CYC` cycles, even if the source goes away or glitches during that time.
- R6: A source pulse longer than `FILT_CYC` cycles is copied at its own length in cycles.
- R7: When the drive ends, the block drives the segment high (enable 1, value 1) for exactly one cycle and then turns its enable off.
- R8: For `GUARD_CYC` cycles after the release cycle, neither input is sampled. After that window, an asserted input is accepted as a new source.
- R9: Each input passes through two synchronizer flops. The drive starts on the second clock edge after the edge that first samples an asserted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in_n | input | 1 | Line level read from segment A, active low |
| b_in_n | input | 1 | Line level read from segment B, active low |
| a_oe | output | 1 | Drive enable for segment A |
| a_out_n | output | 1 | Value driven onto segment A |
| b_oe | output | 1 | Drive enable for segment B |
| b_out_n | output | 1 | Value driven onto segment B |

## Verification
The bench models each segment as a wired-AND line. The block's own drive therefore shows up on its input.
- If the receive path of the driven segment were not blocked, the block would latch itself into the opposite direction.
- A two-cycle pulse must still come out as exactly `FILT_CYC` cycles. A pulse with a glitch in the middle must not stretch or split the output. A long pulse must keep its length. A design with a broken hold counter or a broken source tracking gets these lengths wrong.
- An echo injected inside the guard window must not start a reverse drive. A source that is still held after the window must be accepted.
- Asserting both segments at once checks the priority. A design that gets it wrong drives A, or both segments.

// File: rtl/rep_pkg.sv
package rep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRV_AB,
        ST_DRV_BA,
        ST_RELEASE,
        ST_GUARD
    } rep_state_t;

    typedef enum logic {
        DIR_AB,
        DIR_BA
    } rep_dir_t;

endpackage

// File: rtl/rep_sync.sv
module rep_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Idle level of an active-low line is high, so reset to all ones.
    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stg_q;
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '1;
                else     stg_q <= din;
            end
            assign dout = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_q;
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '1;
                else     stg_q <= {stg_q[STAGES-2:0], din};
            end
            assign dout = stg_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rep_timer.sv
module rep_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R5 / R8: a loaded value is held in the counter on the next cycle
    a_r5_timer_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    // R8: a nonzero count only ever counts down by one
    a_r8_timer_step: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rep_fsm.sv
module rep_fsm
    import rep_pkg::*;
#(
    parameter int CW        = 4,
    parameter int FILT_CYC  = 8,
    parameter int GUARD_CYC = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_act,
    input  logic          b_act,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          a_oe,
    output logic          a_out_n,
    output logic          b_oe,
    output logic          b_out_n
);
    localparam logic [CW-1:0] FILT_LD  = CW'(FILT_CYC - 1);
    localparam logic [CW-1:0] GUARD_LD = CW'(GUARD_CYC - 1);

    rep_state_t st_q, st_d;
    rep_dir_t   dir_q, dir_d;

    // Next state and timer control
    always_comb begin
        st_d     = st_q;
        dir_d    = dir_q;
        tmr_load = 1'b0;
        tmr_val  = FILT_LD;
        unique case (st_q)
            ST_IDLE: begin
                if (a_act) begin
                    st_d     = ST_DRV_AB;
                    dir_d    = DIR_AB;
                    tmr_load = 1'b1;
                end else if (b_act) begin
                    st_d     = ST_DRV_BA;
                    dir_d    = DIR_BA;
                    tmr_load = 1'b1;
                end
            end
            ST_DRV_AB: begin
                // only the source side (A) is looked at; B input is blocked
                if (tmr_zero && !a_act) st_d = ST_RELEASE;
            end
            ST_DRV_BA: begin
                if (tmr_zero && !b_act) st_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                st_d     = ST_GUARD;
                tmr_load = 1'b1;
                tmr_val  = GUARD_LD;
            end
            ST_GUARD: begin
                if (tmr_zero) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            dir_q <= DIR_AB;
        end else begin
            st_q  <= st_d;
            dir_q <= dir_d;
        end
    end

    // Outputs
    always_comb begin
        a_oe    = 1'b0;
        a_out_n = 1'b1;
        b_oe    = 1'b0;
        b_out_n = 1'b1;
        unique case (st_q)
            ST_IDLE:   ;
            ST_DRV_AB: begin b_oe = 1'b1; b_out_n = 1'b0; end
            ST_DRV_BA: begin a_oe = 1'b1; a_out_n = 1'b0; end
            ST_RELEASE: begin
                if (dir_q == DIR_AB) b_oe = 1'b1;
                else                 a_oe = 1'b1;
            end
            ST_GUARD:  ;
            default:   ;
        endcase
    end

    // R4: never both segments driven
    a_r4_one_side: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));

    // R2: a low drive on B starts only out of IDLE
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(b_oe && !b_out_n) |-> ($past(st_q) == ST_IDLE));

    // R3: simultaneous assertion resolves to A-to-B
    a_r3_priority: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && a_act && b_act) |=> (b_oe && !b_out_n && !a_oe));

    // R5: during the hold time the drive cannot end
    a_r5_filter_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRV_AB && !tmr_zero) |=> (b_oe && !b_out_n));

    // R6: a held source keeps the drive on
    a_r6_follow_src: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRV_BA && b_act) |=> (a_oe && !a_out_n));

    // R7: a high release cycle is followed by the enable turning off
    a_r7_release_off: assert property (@(posedge clk) disable iff (rst)
        (a_oe && a_out_n) |=> !a_oe);

    // R8: inputs are ignored while the guard count runs
    a_r8_guard_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_GUARD && !tmr_zero) |=> (!a_oe && !b_oe));

endmodule

// File: rtl/sig_repeater.sv
module sig_repeater
    import rep_pkg::*;
#(
    parameter int FILT_CYC    = 8,
    parameter int GUARD_CYC   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic a_in_n,
    input  logic b_in_n,
    output logic a_oe,
    output logic a_out_n,
    output logic b_oe,
    output logic b_out_n
);
    localparam int MAXC = (FILT_CYC > GUARD_CYC) ? FILT_CYC : GUARD_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic [1:0]    sync_out;
    logic          a_act, b_act;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;

    rep_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({a_in_n, b_in_n}),
        .dout (sync_out)
    );

    assign a_act = ~sync_out[1];
    assign b_act = ~sync_out[0];

    rep_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rep_fsm #(.CW(CW), .FILT_CYC(FILT_CYC), .GUARD_CYC(GUARD_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .a_act    (a_act),
        .b_act    (b_act),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .a_oe     (a_oe),
        .a_out_n  (a_out_n),
        .b_oe     (b_oe),
        .b_out_n  (b_out_n)
    );

    // R1: outputs idle on the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!a_oe && !b_oe && a_out_n && b_out_n));

endmodule

// File: tb/sig_repeater_tb_top.sv
module sig_repeater_tb_top;
    localparam int F = 8;
    localparam int G = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic a_ext_n = 1'b1;
    logic b_ext_n = 1'b1;
    logic a_oe, a_out_n, b_oe, b_out_n;

    // wired-AND bus: the block's own drive appears on its input
    wire a_in_n = a_ext_n & ~(a_oe & ~a_out_n);
    wire b_in_n = b_ext_n & ~(b_oe & ~b_out_n);

    sig_repeater #(.FILT_CYC(F), .GUARD_CYC(G), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .a_in_n(a_in_n), .b_in_n(b_in_n),
        .a_oe(a_oe), .a_out_n(a_out_n), .b_oe(b_oe), .b_out_n(b_out_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit started = 0;

    // behavioural reference: 0 idle, 1 A->B, 2 B->A, 3 release, 4 guard
    int   m_st = 0;
    int   m_cnt = 0;
    int   m_dir = 0;
    logic ma1 = 1, ma2 = 1, mb1 = 1, mb2 = 1;
    logic m_aoe = 0, m_aout = 1, m_boe = 0, m_bout = 1;

    always @(posedge clk) begin
        logic ain, bin, aact, bact;
        ain = a_ext_n & ~(m_aoe & ~m_aout);
        bin = b_ext_n & ~(m_boe & ~m_bout);
        if (rst) begin
            m_st = 0; m_cnt = 0; m_dir = 0;
            ma1 = 1; ma2 = 1; mb1 = 1; mb2 = 1;
        end else begin
            aact = !ma2;
            bact = !mb2;
            if (m_st == 0) begin
                if (aact)      begin m_st = 1; m_cnt = F - 1; m_dir = 0; end
                else if (bact) begin m_st = 2; m_cnt = F - 1; m_dir = 1; end
            end else if (m_st == 1 || m_st == 2) begin
                if (m_cnt > 0) m_cnt--;
                else if ((m_st == 1 && !aact) || (m_st == 2 && !bact)) m_st = 3;
            end else if (m_st == 3) begin
                m_st = 4; m_cnt = G - 1;
            end else begin
                if (m_cnt > 0) m_cnt--;
                else m_st = 0;
            end
            ma2 = ma1; ma1 = ain;
            mb2 = mb1; mb1 = bin;
        end
        m_aoe  = (m_st == 2) || (m_st == 3 && m_dir == 1);
        m_aout = !(m_st == 2);
        m_boe  = (m_st == 1) || (m_st == 3 && m_dir == 0);
        m_bout = !(m_st == 1);
        started = 1;
    end

    // pulse-shape monitors
    int a_low = 0, b_low = 0, a_rel = 0, b_rel = 0, both_on = 0;

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if ({a_oe, a_out_n, b_oe, b_out_n} !== {m_aoe, m_aout, m_boe, m_bout}) begin
                fails++;
                $display("FAIL R9 cycle model t=%0t: got %b expected %b", $time,
                         {a_oe, a_out_n, b_oe, b_out_n}, {m_aoe, m_aout, m_boe, m_bout});
            end
            if (a_oe && !a_out_n) a_low++;
            if (b_oe && !b_out_n) b_low++;
            if (a_oe && a_out_n)  a_rel++;
            if (b_oe && b_out_n)  b_rel++;
            if (a_oe && b_oe)     both_on++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        a_low = 0; b_low = 0; a_rel = 0; b_rel = 0; both_on = 0;
    endtask

    task automatic pulse_a(input int len);
        @(negedge clk); a_ext_n = 1'b0;
        repeat (len) @(negedge clk);
        a_ext_n = 1'b1;
    endtask

    task automatic pulse_b(input int len);
        @(negedge clk); b_ext_n = 1'b0;
        repeat (len) @(negedge clk);
        b_ext_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 a_oe", int'(a_oe), 0);
        check("R1 b_oe", int'(b_oe), 0);
        check("R1 outs", int'({a_out_n, b_out_n}), 3);
        rst = 1'b0;

        // R5: short pulse stretched to hold time
        clr(); pulse_a(2); repeat (40) @(negedge clk);
        check("R5 short pulse width", b_low, F);
        check("R7 release cycles", b_rel, 1);
        check("R4 no reverse drive", a_low, 0);

        // R6: long pulse copied at its own length
        clr(); pulse_a(20); repeat (40) @(negedge clk);
        check("R6 long pulse width", b_low, 20);
        check("R7 release cycles", b_rel, 1);

        // R2: B to A direction
        clr(); pulse_b(12); repeat (40) @(negedge clk);
        check("R2 B to A width", a_low, 12);
        check("R4 B not driven", b_low, 0);

        // R5: glitch inside hold time
        clr();
        pulse_a(2); repeat (2) @(negedge clk); a_ext_n = 1'b0;
        repeat (2) @(negedge clk); a_ext_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R5 glitched pulse width", b_low, F);

        // R3: simultaneous assertion
        clr();
        @(negedge clk); a_ext_n = 1'b0; b_ext_n = 1'b0;
        repeat (3) @(negedge clk); a_ext_n = 1'b1; b_ext_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R3 B driven", b_low, F);
        check("R3 A not driven", a_low, 0);

        // R8: echo inside guard window ignored
        clr();
        pulse_a(2);
        while (!(b_oe && b_out_n)) @(negedge clk);
        @(negedge clk);
        b_ext_n = 1'b0; repeat (2) @(negedge clk); b_ext_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R8 echo ignored", a_low, 0);
        check("R8 forward pulse", b_low, F);

        // R8: source still held after guard is accepted
        clr();
        pulse_a(2);
        while (!(b_oe && b_out_n)) @(negedge clk);
        @(negedge clk);
        b_ext_n = 1'b0; repeat (20) @(negedge clk); b_ext_n = 1'b1;
        repeat (40) @(negedge clk);
        check("R8 accepted after guard", int'(a_low > 0), 1);

        // R1: reset in the middle of a drive
        clr();
        @(negedge clk); a_ext_n = 1'b0;
        repeat (5) @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; a_ext_n = 1'b1;
        check("R1 mid-drive reset b_oe", int'(b_oe), 0);
        repeat (20) @(negedge clk);

        check("R4 never both enabled", both_on, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule